// File: doc/BRIEF.md
# Fan Tachometer Measurement Counter

This block measures the speed of a fan from its tachometer output. The tach line is brought into the core clock domain by a synchronizer. An optional stability filter can then clean it. The block opens a measurement window on a rising tach edge and closes it after a programmed number of rising edges. Across that window a 16-bit counter advances, either on rising tach edges or on a single-cycle strobe that marks each rising edge of a slow reference clock. When a window closes, the count is latched and checked against a low and a high threshold. The counter then starts again for the next window, and the closing edge also opens the next window.

Software sees three registers through a plain single-cycle write strobe and a combinational read port:

| Address | Contents |
|---|---|
| 0 | Control. The latched count reads back in its upper half. |
| 1 | Status. Sticky event flags, cleared by writing one. |
| 2 | Limits. Low threshold in the lower half, high threshold in the upper half. |

The register port carries control, not a data stream, so it has no valid/ready handshake and never applies back-pressure: every strobed write takes effect at that clock edge. A single interrupt line combines the three status flags, each through its own enable.

Top module: `tach_meter`

## Requirements
- R1: After reset, address 0 reads 0, address 1 reads 0, address 2 reads 0xFFFF0000 (low 0, high 0xFFFF), and `irq` is low.
- R2: `tach_in` passes two synchronizing flops. With the filter off, every change of the synchronized level is accepted. Each accepted level change sets status bit 2 (toggle) while control bit 0 (run) is set, including a pulse only two cycles wide.
- R3: With control bit 1 (filter) set, a level change is accepted only once the synchronized input has held the new level for 3 consecutive clocks. A 2-cycle pulse leaves status bit 2 clear.
- R4: Control bits [4:3] select the window length as 0→2, 1→3, 2→5 and 3→9 rising edges. The first accepted rising edge after enabling opens a window. The closing edge latches the count and also opens the next window.
- R5: With control bit 2 (source) clear, the counter advances once per accepted rising tach edge, so a completed window latches the window length minus one.
- R6: With control bit 2 set, the counter advances once per cycle with `ref_tick` high. The cycle of the opening edge does not count; the cycles after it, up to and including the closing edge, do.
- R7: The counter saturates at 0xFFFF and never wraps.
- R8: Every latch sets status bit 1 (ready). It also sets status bit 0 (out of limit) when the count is below the low limit or above the high limit; a count equal to either limit is within range.
- R9: Writing address 1 clears each status bit written as 1 and leaves the others. A flag raised in the same cycle stays set.
- R10: `irq` is the OR of status bit 0 with control bit 5, status bit 1 with control bit 6, and status bit 2 with control bit 7.
- R11: While control bit 0 is clear, no window runs, no flag is raised, and the latched count holds its value.
- R12: Address 0 reads the written control byte in bits [7:0], zeros in bits [15:8], and the latched count in bits [31:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_in | input | 1 | Raw fan tachometer line, asynchronous |
| ref_tick | input | 1 | One-cycle strobe per rising edge of the slow reference clock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches, on every cycle, that:
- the ready and out-of-limit flags rise only after a latch pulse;
- the toggle flag rises only after an accepted change while running;
- the latched count never moves outside a latch;
- no latch follows a cycle with run clear;
- the interrupt stays low while no flag is set.

Only the bench's scenarios can show the following:
- the filter's exact three-sample rule;
- the exact count values for each window length and source;
- saturation over a long window;
- the inclusive limit boundaries;
- the write-one-to-clear behaviour.

The bench's reference model is compared against the read port and the interrupt on every cycle.

// File: rtl/tach_pkg.sv
package tach_pkg;

  localparam int CNT_W  = 16;
  localparam int EDGE_W = 4;
  localparam int STAT_W = 3;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_STAT  = 2'd1,
    ADDR_LIMIT = 2'd2
  } reg_addr_e;

  // bit 0 run, 1 filter, 2 source, 4:3 span, 5..7 interrupt enables
  typedef struct packed {
    logic       ie_tog;
    logic       ie_rdy;
    logic       ie_ool;
    logic [1:0] span_sel;
    logic       ref_mode;
    logic       filt_en;
    logic       run_en;
  } ctrl_t;

  function automatic logic [EDGE_W-1:0] span_edges(input logic [1:0] sel);
    logic [EDGE_W-1:0] n;
    case (sel)
      2'd0:    n = EDGE_W'(2);
      2'd1:    n = EDGE_W'(3);
      2'd2:    n = EDGE_W'(5);
      default: n = EDGE_W'(9);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tach_input_cond.sv
module tach_input_cond #(
  parameter int SYNC_N   = 2,
  parameter int STABLE_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_in,
  input  logic filt_en,
  output logic lvl_q,
  output logic rise_p,
  output logic chg_p
);

  localparam int HIST_W = STABLE_N - 1;

  logic [SYNC_N-1:0] sync_q;
  logic [HIST_W-1:0] hist_q;
  logic              smp;
  logic              steady;
  logic              accept;

  assign smp = sync_q[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      sync_q    <= {sync_q[SYNC_N-2:0], tach_in};
      hist_q[0] <= smp;
      for (int i = 1; i < HIST_W; i++) begin
        hist_q[i] <= hist_q[i-1];
      end
    end
  end

  always_comb begin
    steady = (hist_q == {HIST_W{smp}});
    accept = (smp != lvl_q) && (!filt_en || steady);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      rise_p <= 1'b0;
      chg_p  <= 1'b0;
    end else begin
      if (accept) lvl_q <= smp;
      rise_p <= accept & smp;
      chg_p  <= accept;
    end
  end

endmodule

// File: rtl/tach_span_counter.sv
module tach_span_counter
  import tach_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             ref_mode,
  input  logic [1:0]       span_sel,
  input  logic             rise_p,
  input  logic             ref_tick,
  output logic [CNT_W-1:0] latch_q,
  output logic             done_p
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  bumped;
  logic [EDGE_W-1:0] edges_q;
  logic [EDGE_W:0]   edges_nx;
  logic              armed_q;
  logic              inc;
  logic              closing;

  always_comb begin
    inc      = ref_mode ? ref_tick : rise_p;
    bumped   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(inc);
    edges_nx = {1'b0, edges_q} + (EDGE_W+1)'(1);
    closing  = edges_nx >= {1'b0, span_edges(span_sel)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      edges_q <= '0;
      armed_q <= 1'b0;
      latch_q <= '0;
      done_p  <= 1'b0;
    end else begin
      done_p <= 1'b0;
      if (!run_en) begin
        cnt_q   <= '0;
        edges_q <= '0;
        armed_q <= 1'b0;
      end else if (rise_p) begin
        if (!armed_q) begin
          armed_q <= 1'b1;
          edges_q <= EDGE_W'(1);
          cnt_q   <= '0;
        end else if (closing) begin
          latch_q <= bumped;
          done_p  <= 1'b1;
          cnt_q   <= '0;
          edges_q <= EDGE_W'(1);
        end else begin
          edges_q <= edges_nx[EDGE_W-1:0];
          cnt_q   <= bumped;
        end
      end else if (armed_q) begin
        cnt_q <= bumped;
      end
    end
  end

endmodule

// File: rtl/tach_status.sv
module tach_status
  import tach_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              done_p,
  input  logic              chg_p,
  input  logic [CNT_W-1:0]  latch_q,
  input  logic [CNT_W-1:0]  lim_lo,
  input  logic [CNT_W-1:0]  lim_hi,
  input  logic [STAT_W-1:0] clr_mask,
  input  logic [STAT_W-1:0] ie,
  output logic [STAT_W-1:0] stat_q,
  output logic              irq
);

  logic [STAT_W-1:0] set_v;

  always_comb begin
    set_v[0] = done_p && ((latch_q < lim_lo) || (latch_q > lim_hi));
    set_v[1] = done_p;
    set_v[2] = chg_p && run_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_mask) | set_v;
  end

  assign irq = |(stat_q & ie);

endmodule

// File: rtl/tach_meter.sv
module tach_meter
  import tach_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tach_in,
  input  logic        ref_tick,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);

  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  lim_lo_q;
  logic [CNT_W-1:0]  lim_hi_q;
  logic [CNT_W-1:0]  latch_q;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] clr_mask;
  logic              in_lvl;
  logic              in_rise;
  logic              in_chg;
  logic              span_done;
  logic              wr_ctrl;
  logic              wr_stat;
  logic              wr_lim;

  always_comb begin
    wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
    wr_stat  = reg_wr && (reg_addr == ADDR_STAT);
    wr_lim   = reg_wr && (reg_addr == ADDR_LIMIT);
    clr_mask = wr_stat ? reg_wdata[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      lim_lo_q <= '0;
      lim_hi_q <= '1;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[7:0]);
      if (wr_lim) begin
        lim_lo_q <= reg_wdata[CNT_W-1:0];
        lim_hi_q <= reg_wdata[2*CNT_W-1:CNT_W];
      end
    end
  end

  tach_input_cond #(.SYNC_N(2), .STABLE_N(3)) u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .tach_in (tach_in),
    .filt_en (ctrl_q.filt_en),
    .lvl_q   (in_lvl),
    .rise_p  (in_rise),
    .chg_p   (in_chg)
  );

  tach_span_counter u_span (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (ctrl_q.run_en),
    .ref_mode (ctrl_q.ref_mode),
    .span_sel (ctrl_q.span_sel),
    .rise_p   (in_rise),
    .ref_tick (ref_tick),
    .latch_q  (latch_q),
    .done_p   (span_done)
  );

  tach_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (ctrl_q.run_en),
    .done_p   (span_done),
    .chg_p    (in_chg),
    .latch_q  (latch_q),
    .lim_lo   (lim_lo_q),
    .lim_hi   (lim_hi_q),
    .clr_mask (clr_mask),
    .ie       ({ctrl_q.ie_tog, ctrl_q.ie_rdy, ctrl_q.ie_ool}),
    .stat_q   (stat_q),
    .irq      (irq)
  );

  always_comb begin
    case (reg_addr)
      ADDR_CTRL:  reg_rdata = {latch_q, 8'h00, ctrl_q};
      ADDR_STAT:  reg_rdata = {{(32-STAT_W){1'b0}}, stat_q};
      ADDR_LIMIT: reg_rdata = {lim_hi_q, lim_lo_q};
      default:    reg_rdata = '0;
    endcase
  end

  logic unused_lvl;
  assign unused_lvl = in_lvl;

endmodule

// File: rtl/tach_meter_chk.sv
module tach_meter_chk
  import tach_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              done_p,
  input logic              chg_p,
  input logic [STAT_W-1:0] stat,
  input logic [CNT_W-1:0]  latch,
  input logic              irq
);

  AST_RDY_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[1]) |-> $past(done_p)); // R8
  AST_OOL_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[0]) |-> $past(done_p)); // R8
  AST_TOG_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[2]) |-> $past(chg_p && run_en)); // R2
  AST_NO_LATCH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !done_p); // R11
  AST_LATCH_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latch) |-> done_p); // R4
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == '0) |-> !irq); // R10

endmodule

bind tach_meter tach_meter_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .run_en (ctrl_q.run_en),
  .done_p (span_done),
  .chg_p  (in_chg),
  .stat   (stat_q),
  .latch  (latch_q),
  .irq    (irq)
);

// File: tb/tach_meter_bench.sv
module tach_meter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tach_in = 1'b0;
  logic        ref_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;
  int tick_mode = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tach_meter u_tach_meter (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .ref_tick(ref_tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  bit          m_s1, m_s2, m_lvl, m_rise, m_chg, m_armed, m_done;
  int          m_run, m_edges, m_cnt;
  int          m_latch;
  bit [2:0]    m_stat;
  logic [7:0]  m_ctrl;
  int          m_lo, m_hi;

  function automatic int span_of(input logic [1:0] s);
    int n;
    if (s == 0) n = 2; else if (s == 1) n = 3; else if (s == 2) n = 5; else n = 9;
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_lvl = 0; m_rise = 0; m_chg = 0;
      m_armed = 0; m_done = 0; m_run = 3; m_edges = 0; m_cnt = 0;
      m_latch = 0; m_stat = 0; m_ctrl = 0; m_lo = 0; m_hi = 65535;
    end else begin
      automatic bit run = m_ctrl[0];
      automatic bit acc;
      automatic int inc, bump;
      automatic bit [2:0] clr = (reg_wr && reg_addr == 2'd1) ? reg_wdata[2:0] : 3'b000;
      automatic bit [2:0] setv;
      setv[0] = m_done && (m_latch < m_lo || m_latch > m_hi);
      setv[1] = m_done;
      setv[2] = m_chg && run;
      m_stat = (m_stat & ~clr) | setv;
      inc  = m_ctrl[2] ? int'(ref_tick) : int'(m_rise);
      bump = (m_cnt + inc > 65535) ? 65535 : m_cnt + inc;
      m_done = 0;
      if (!run) begin
        m_armed = 0; m_cnt = 0; m_edges = 0;
      end else if (m_rise) begin
        if (!m_armed) begin m_armed = 1; m_edges = 1; m_cnt = 0; end
        else if (m_edges + 1 >= span_of(m_ctrl[4:3])) begin
          m_latch = bump; m_done = 1; m_cnt = 0; m_edges = 1;
        end else begin m_edges++; m_cnt = bump; end
      end else if (m_armed) m_cnt = bump;
      acc = (m_s2 != m_lvl) && (!m_ctrl[1] || m_run >= 3);
      m_rise = acc && m_s2;
      m_chg = acc;
      if (acc) m_lvl = m_s2;
      m_run = (m_s1 == m_s2) ? ((m_run < 3) ? m_run + 1 : 3) : 1;
      m_s2 = m_s1;
      m_s1 = tach_in;
      if (reg_wr && reg_addr == 2'd0) m_ctrl = reg_wdata[7:0];
      if (reg_wr && reg_addr == 2'd2) begin
        m_lo = int'(reg_wdata[15:0]); m_hi = int'(reg_wdata[31:16]);
      end
    end
  end

  function automatic logic [31:0] model_rd(input logic [1:0] a);
    logic [31:0] r;
    case (a)
      2'd0: r = {m_latch[15:0], 8'h00, m_ctrl};
      2'd1: r = {29'd0, m_stat};
      2'd2: r = {m_hi[15:0], m_lo[15:0]};
      default: r = 32'd0;
    endcase
    return r;
  endfunction

  // compare against the model every cycle, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic logic [31:0] e = model_rd(reg_addr);
      automatic logic ei = |(m_stat & {m_ctrl[7], m_ctrl[6], m_ctrl[5]});
      tests++;
      if (reg_rdata !== e) begin
        fails++;
        $display("FAIL R12 model read addr %0d got %h exp %h", reg_addr, reg_rdata, e);
      end
      tests++;
      if (irq !== ei) begin
        fails++;
        $display("FAIL R10 model irq got %b exp %b", irq, ei);
      end
    end
  end

  // reference clock strobe generator
  int tcount = 0;
  always @(posedge clk) begin
    #1;
    tcount++;
    ref_tick <= (tick_mode == 1) || (tick_mode == 2 && tcount % 3 == 0);
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic set_ctrl(input logic [7:0] v);
    wr(2'd0, 32'd0);
    wr(2'd0, {24'd0, v});
  endtask

  task automatic wave(input int period, input int n);
    for (int i = 0; i < n; i++) begin
      tach_in = 1'b1; step(period / 2);
      tach_in = 1'b0; step(period - period / 2);
    end
  endtask

  task automatic chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    reg_addr = a;
    @(negedge clk);
    tests++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr %0d got %h exp %h", tag, a, reg_rdata, exp);
    end
    step(1);
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    @(negedge clk);
    tests++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq got %b exp %b", tag, irq, exp);
    end
    step(1);
  endtask

  initial begin
    fork
      begin
        step(200000);
        if (!done) begin
          fails++; tests++;
          $display("FAIL watchdog expired");
          done = 1;
          $display("  [TB] %0d tests run, %0d failed", tests, fails);
          $finish;
        end
      end
    join_none

    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    chk("R1 ctrl", 2'd0, 32'h0000_0000);
    chk("R1 status", 2'd1, 32'h0);
    chk("R1 limits", 2'd2, 32'hFFFF_0000);
    chk_irq("R1", 1'b0);

    // R5 edge source, 3-edge window, limits 2..10 inclusive (R8)
    wr(2'd2, {16'd10, 16'd2});
    set_ctrl(8'h49);
    wave(10, 4);
    step(8);
    chk("R12 R5 count", 2'd0, {16'd2, 16'h0049});
    chk("R8 R2 ready+toggle, no limit", 2'd1, 32'd6);
    chk_irq("R10 ready enabled", 1'b1);

    // R9 write-one-to-clear only the ready bit
    wr(2'd1, 32'd2);
    chk("R9 selective clear", 2'd1, 32'd4);
    chk_irq("R10 toggle not enabled", 1'b0);

    // R6 reference source, every cycle, 2-edge window, period 40
    wr(2'd2, {16'd30, 16'd0});
    tick_mode = 1;
    set_ctrl(8'h25);
    wr(2'd1, 32'd7);
    wave(40, 2);
    step(8);
    tick_mode = 0;
    chk("R6 count", 2'd0, {16'd40, 16'h0025});
    chk("R8 above high", 2'd1, 32'd7);
    chk_irq("R10 limit enabled", 1'b1);

    // R4 window lengths 9 and 5 with edge source
    wr(2'd2, {16'hFFFF, 16'd0});
    set_ctrl(8'h19);
    wave(8, 10);
    step(8);
    chk("R4 sel3 nine edges", 2'd0, {16'd8, 16'h0019});
    set_ctrl(8'h11);
    wave(8, 6);
    step(8);
    chk("R4 sel2 five edges", 2'd0, {16'd4, 16'h0011});

    // R2 unfiltered two-cycle pulse is accepted
    set_ctrl(8'h01);
    wr(2'd1, 32'd7);
    tach_in = 1'b1; step(2); tach_in = 1'b0; step(8);
    chk("R2 short pulse seen", 2'd1, 32'd4);

    // R3 filtered: two-cycle pulse rejected, three-cycle accepted
    set_ctrl(8'h03);
    wr(2'd1, 32'd7);
    tach_in = 1'b1; step(2); tach_in = 1'b0; step(8);
    chk("R3 glitch rejected", 2'd1, 32'd0);
    tach_in = 1'b1; step(3); tach_in = 1'b0; step(8);
    chk("R3 stable level accepted", 2'd1, 32'd4);

    // R11 disabled: no flags, latched count held
    set_ctrl(8'h01);
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd7);
    wave(8, 4);
    step(8);
    chk("R11 no flags", 2'd1, 32'd0);
    chk("R11 count held", 2'd0, {16'd4, 16'h0000});

    // R7 saturation, count at 0xFFFF equals high limit (R8 inclusive)
    tick_mode = 1;
    set_ctrl(8'h05);
    wr(2'd1, 32'd7);
    tach_in = 1'b1; step(2); tach_in = 1'b0; step(65998);
    tach_in = 1'b1; step(2); tach_in = 1'b0; step(8);
    tick_mode = 0;
    chk("R7 saturated", 2'd0, {16'hFFFF, 16'h0005});
    chk("R8 at high limit not out", 2'd1, 32'd6);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule